// File: doc/BRIEF.md
# Externally Synchronized Sample Scheduler

This block decides when a downstream voltage-drop detector should take a sample. It watches a single level input that doubles as a sync channel and as a clear command. A short high pulse on that input is a sync pulse, and its falling edge requests one sample. A long high level is a command to wipe the detector's sample history. While sync pulses keep arriving often enough, the block stays in synchronized operation. When they stop, it falls back to issuing requests on its own at a fixed free-running interval.

All time is measured in ticks of an external strobe, nominally one microsecond, so every threshold is a parameter counted in ticks:
- the longest qualifying pulse (3.5 ms by default),
- the clear threshold (12 ms),
- the two sync windows selected by the timer mode (18.7 s and 9.4 s),
- the free-running interval (17 s).

A test can shrink all of them. The outputs are single-cycle strobes.

Top module: `sync_sample_sched`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `sample_req` and `hist_clr` are low, and the block starts in free-running operation with its interval count at zero.
- R2: A high time of at least 1 and at most P_PULSE_MAX ticks is a qualified sync pulse. The cycle in which `sync_in` is first seen low after such a high time is the fall cycle, and `sample_req` is high for exactly the cycle after it. The high time is the number of cycles in which `tick_us` and `sync_in` were both high.
- R3: A high time of zero ticks produces neither a request nor a clear.
- R4: A high time from P_PULSE_MAX+1 up to and including P_CLEAR ticks produces neither a request nor a clear.
- R5: Outside the sync window, `sample_req` pulses once every P_FREE ticks. The count starts from reset, or from zero when the sync window closes.
- R6: When a high level sees its (P_CLEAR+1)-th tick, `hist_clr` pulses in the next cycle, once per high level. The falling edge that ends such a level issues no request.
- R7: A qualified pulse opens a sync window and restarts it if one is already open. No free-running request is issued inside the window. The window closes after a number of ticks with no qualified pulse. That number is P_WIN_LOWMID for `tm_sel` 2'b00 (low) and 2'b01 (mid). It is P_WIN_HIGH for 2'b10 (high) and 2'b11 (reserved, treated as high).
- R8: `sample_req` and `hist_clr` are never high in the same cycle. When a free-running request falls due in the cycle that triggers a clear, the clear is issued and that request is dropped.
- R9: `hist_clr` never stays high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_us | input | 1 | Time-base strobe, one cycle per tick |
| sync_in | input | 1 | Inhibit/sync level; short highs are sync pulses, long highs are clear commands |
| tm_sel | input | 2 | Timer mode: 00 low, 01 mid, 10 high, 11 treated as high |
| sample_req | output | 1 | One-cycle request to take a sample |
| hist_clr | output | 1 | One-cycle request to erase the sample history |

## Verification
The hardest situation to reach from the ports is a clear command whose triggering tick is the same tick on which a free-running request falls due. The high level has to begin exactly P_FREE−P_CLEAR−1 ticks after reset. A directed case counts ticks from reset release, raises `sync_in` right after the chosen tick and holds it. It then expects one clear and no request. Random pulse widths spanning all four width bands, random gaps and random mode changes are also compared cycle by cycle against a bench model written from the requirements. This comparison covers window expiry in both modes.

// File: rtl/sched_pkg.sv
package sched_pkg;

  typedef enum logic [1:0] {
    TM_LOW  = 2'b00,
    TM_MID  = 2'b01,
    TM_HIGH = 2'b10,
    TM_RSV  = 2'b11
  } tm_sel_e;

  // Upper bit set selects the short sync window (high and reserved).
  function automatic logic short_window(input logic [1:0] tm);
    return tm[1];
  endfunction

  function automatic logic [31:0] window_limit(input logic [1:0] tm,
                                               input logic [31:0] lim_lowmid,
                                               input logic [31:0] lim_high);
    return short_window(tm) ? lim_high : lim_lowmid;
  endfunction

  // A high time qualifies as a sync pulse when it spans 1..pmax ticks.
  function automatic logic width_qualifies(input logic [31:0] width,
                                           input logic [31:0] pmax);
    return (width != 32'd0) && (width <= pmax);
  endfunction

  function automatic logic [31:0] max2(input logic [31:0] a, input logic [31:0] b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pulse_qual.sv
module pulse_qual
  import sched_pkg::*;
#(
  parameter int unsigned PMAX  = 3500,
  parameter int unsigned CLEAR = 12000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic level,
  output logic sync_evt,
  output logic clr_evt
);
  localparam int unsigned HW = $clog2(CLEAR + 2);

  logic          prev_q;
  logic [HW-1:0] hi_cnt;
  logic          fall;

  assign fall     = prev_q & ~level;
  assign sync_evt = fall && width_qualifies(32'(hi_cnt), PMAX);
  assign clr_evt  = level && tick && (32'(hi_cnt) == CLEAR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      hi_cnt <= '0;
    end else begin
      prev_q <= level;
      if (!level)
        hi_cnt <= '0;
      else if (tick && (32'(hi_cnt) <= CLEAR))
        hi_cnt <= hi_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sync_window.sv
module sync_window
  import sched_pkg::*;
#(
  parameter int unsigned LIM_LOWMID = 18700000,
  parameter int unsigned LIM_HIGH   = 9400000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [1:0] tm,
  input  logic       sync_evt,
  output logic       in_window,
  output logic       win_expire
);
  localparam int unsigned MAXL = (LIM_LOWMID > LIM_HIGH) ? LIM_LOWMID : LIM_HIGH;
  localparam int unsigned WW   = $clog2(MAXL + 1);

  logic [WW-1:0] since_q;
  logic [31:0]   limit;

  assign limit      = window_limit(tm, LIM_LOWMID, LIM_HIGH);
  assign win_expire = in_window && tick && !sync_evt && ((32'(since_q) + 32'd1) >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_window <= 1'b0;
      since_q   <= '0;
    end else if (sync_evt) begin
      in_window <= 1'b1;
      since_q   <= '0;
    end else if (win_expire) begin
      in_window <= 1'b0;
      since_q   <= '0;
    end else if (in_window && tick) begin
      since_q   <= since_q + 1'b1;
    end
  end
endmodule

// File: rtl/free_timer.sv
module free_timer #(
  parameter int unsigned PERIOD = 17000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic in_window,
  input  logic sync_evt,
  output logic free_evt
);
  localparam int unsigned FW = $clog2(PERIOD + 1);

  logic [FW-1:0] cnt_q;

  assign free_evt = !in_window && tick && !sync_evt && ((32'(cnt_q) + 32'd1) >= PERIOD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (sync_evt)
      cnt_q <= '0;
    else if (!in_window && tick)
      cnt_q <= free_evt ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/sync_sample_sched.sv
module sync_sample_sched #(
  parameter int unsigned P_PULSE_MAX  = 3500,
  parameter int unsigned P_CLEAR      = 12000,
  parameter int unsigned P_WIN_LOWMID = 18700000,
  parameter int unsigned P_WIN_HIGH   = 9400000,
  parameter int unsigned P_FREE       = 17000000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_us,
  input  logic       sync_in,
  input  logic [1:0] tm_sel,
  output logic       sample_req,
  output logic       hist_clr
);
  logic sync_evt;
  logic clr_evt;
  logic in_window;
  logic win_expire;
  logic free_evt;

  pulse_qual #(.PMAX(P_PULSE_MAX), .CLEAR(P_CLEAR)) u_qual (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_us),
    .level    (sync_in),
    .sync_evt (sync_evt),
    .clr_evt  (clr_evt)
  );

  sync_window #(.LIM_LOWMID(P_WIN_LOWMID), .LIM_HIGH(P_WIN_HIGH)) u_win (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick_us),
    .tm         (tm_sel),
    .sync_evt   (sync_evt),
    .in_window  (in_window),
    .win_expire (win_expire)
  );

  free_timer #(.PERIOD(P_FREE)) u_free (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick_us),
    .in_window (in_window),
    .sync_evt  (sync_evt),
    .free_evt  (free_evt)
  );

  // A clear suppresses a coincident free-running request (R8).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sample_req <= 1'b0;
      hist_clr   <= 1'b0;
    end else begin
      sample_req <= sync_evt | (free_evt & ~clr_evt);
      hist_clr   <= clr_evt;
    end
  end
endmodule

// File: rtl/sched_chk.sv
module sched_chk (
  input logic clk,
  input logic rst_n,
  input logic sync_in,
  input logic sample_req,
  input logic hist_clr,
  input logic sync_evt,
  input logic clr_evt
);
  assert_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_req && hist_clr));

  assert_clr_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hist_clr |=> !hist_clr);

  assert_clr_on_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hist_clr |-> $past(sync_in));

  assert_clr_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt |=> hist_clr);

  assert_sync_request_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sync_evt |=> sample_req);
endmodule

bind sync_sample_sched sched_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sync_in    (sync_in),
  .sample_req (sample_req),
  .hist_clr   (hist_clr),
  .sync_evt   (sync_evt),
  .clr_evt    (clr_evt)
);

// File: tb/tb_sync_sample_sched.sv
`timescale 1ns/1ps
module tb_sync_sample_sched;
  localparam int PM = 6;
  localparam int CL = 15;
  localparam int LM = 120;
  localparam int HI = 60;
  localparam int FR = 100;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       sync_in = 1'b0;
  logic [1:0] tm = 2'b00;
  logic       sample_req, hist_clr;

  int total = 0, bad = 0;
  int req_cnt = 0, clr_cnt = 0;
  logic exp_req = 1'b0, exp_clr = 1'b0;
  string cause = "R9";

  always #2.5 clk = ~clk;
  always @(negedge clk) tick <= ~tick;

  sync_sample_sched #(.P_PULSE_MAX(PM), .P_CLEAR(CL), .P_WIN_LOWMID(LM),
                      .P_WIN_HIGH(HI), .P_FREE(FR)) dut (
    .clk(clk), .rst_n(rst_n), .tick_us(tick), .sync_in(sync_in), .tm_sel(tm),
    .sample_req(sample_req), .hist_clr(hist_clr));

  task automatic chk(input string tag, input string what, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s: got=%0d exp=%0d", tag, what, got, exp);
    end
  endtask

  // Reference model, written from the requirements, stepped on each edge.
  int  m_hi = 0, m_since = 0, m_free = 0;
  bit  m_prev = 0, m_win = 0;
  always @(posedge clk) begin
    bit qual, clr, fe;
    int lim;
    if (!rst_n) begin
      m_hi = 0; m_since = 0; m_free = 0; m_prev = 0; m_win = 0;
      exp_req = 0; exp_clr = 0;
    end else begin
      lim  = (tm == 2'b10 || tm == 2'b11) ? HI : LM;
      qual = m_prev && !sync_in && (m_hi >= 1) && (m_hi <= PM);
      clr  = sync_in && tick && (m_hi == CL);
      fe   = 0;
      if (qual) m_free = 0;
      else if (!m_win && tick) begin
        m_free++;
        if (m_free == FR) begin fe = 1; m_free = 0; end
      end
      if (qual) begin m_win = 1; m_since = 0; end
      else if (m_win && tick) begin
        m_since++;
        if (m_since >= lim) begin m_win = 0; m_since = 0; end
      end
      if (!sync_in) m_hi = 0;
      else if (tick && m_hi <= CL) m_hi++;
      m_prev  = sync_in;
      exp_req = qual || (fe && !clr);
      exp_clr = clr;
      cause   = clr ? (fe ? "R8" : "R6") : qual ? "R2" : fe ? "R5" : "R9";
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      req_cnt += int'(sample_req);
      clr_cnt += int'(hist_clr);
      if (exp_req || exp_clr || sample_req || hist_clr) begin
        chk(cause, "model sample_req", int'(sample_req), int'(exp_req));
        chk(cause, "model hist_clr", int'(hist_clr), int'(exp_clr));
      end
    end
  end

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0; sync_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_ticks(input int n);
    int k = 0;
    while (k < n) begin @(posedge clk); if (tick) k++; end
  endtask

  task automatic pulse(input int n);
    @(negedge clk) sync_in = 1'b1;
    wait_ticks(n);
    @(negedge clk) sync_in = 1'b0;
  endtask

  task automatic pulse_zero();
    do @(posedge clk); while (!tick);
    @(negedge clk) sync_in = 1'b1;
    @(negedge clk) sync_in = 1'b0;
  endtask

  task automatic refresh_window();
    pulse(2);
    repeat (4) @(negedge clk);
    req_cnt = 0; clr_cnt = 0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: got=timeout exp=done");
    finish_run();
  end

  initial begin
    int seed = 32'h5EED_2002;
    void'($urandom(seed));
    @(negedge clk);
    chk("R1", "sample_req in reset", int'(sample_req), 0);
    chk("R1", "hist_clr in reset", int'(hist_clr), 0);
    do_reset();
    @(negedge clk);
    chk("R1", "sample_req after reset", int'(sample_req), 0);
    // R5: free-running from reset
    req_cnt = 0;
    wait_ticks(3 * FR + 2);
    settle();
    chk("R5", "free requests in 3 periods", req_cnt, 3);

    tm = 2'b00;
    refresh_window(); pulse(3); settle();
    chk("R2", "3-tick pulse requests", req_cnt, 1);
    refresh_window(); pulse(1); settle();
    chk("R2", "1-tick pulse requests", req_cnt, 1);
    refresh_window(); pulse(PM); settle();
    chk("R2", "max-width pulse requests", req_cnt, 1);
    refresh_window(); pulse_zero(); settle();
    chk("R3", "zero-tick pulse requests", req_cnt, 0);
    chk("R3", "zero-tick pulse clears", clr_cnt, 0);
    refresh_window(); pulse(PM + 1); settle();
    chk("R4", "over-width pulse requests", req_cnt, 0);
    refresh_window(); pulse(CL); settle();
    chk("R4", "clear-length high requests", req_cnt, 0);
    chk("R4", "clear-length high clears", clr_cnt, 0);
    refresh_window(); pulse(CL + 1); settle();
    chk("R6", "just-long high clears", clr_cnt, 1);
    chk("R6", "just-long high requests", req_cnt, 0);
    refresh_window(); pulse(CL + 8); settle();
    chk("R9", "long high clears once", clr_cnt, 1);

    // R7: window length by mode
    tm = 2'b00;
    refresh_window(); wait_ticks(200); settle();
    chk("R7", "low mode quiet window", req_cnt, 0);
    tm = 2'b10;
    refresh_window(); wait_ticks(170); settle();
    chk("R7", "high mode expiry then free request", req_cnt, 1);
    tm = 2'b11;
    refresh_window(); wait_ticks(170); settle();
    chk("R7", "reserved mode acts as high", req_cnt, 1);

    // R8: clear trigger on the tick a free request falls due
    tm = 2'b00;
    do_reset();
    req_cnt = 0; clr_cnt = 0;
    wait_ticks(FR - CL - 1);
    @(negedge clk) sync_in = 1'b1;
    wait_ticks(CL + 3);
    @(negedge clk) sync_in = 1'b0;
    settle();
    chk("R8", "coincident clear issued", clr_cnt, 1);
    chk("R8", "coincident free request dropped", req_cnt, 0);

    // Random phase, checked by the model
    do_reset();
    for (int i = 0; i < 400; i++) begin
      int w, g;
      tm = 2'($urandom_range(0, 3));
      w  = $urandom_range(0, CL + 4);
      if (w == 0) pulse_zero(); else pulse(w);
      g = ($urandom_range(0, 7) == 0) ? $urandom_range(60, 250) : $urandom_range(0, 40);
      wait_ticks(g);
    end
    settle();
    finish_run();
  end
endmodule